// File: doc/BRIEF.md
# Scanline Memory Slot Arbiter

This block decides, once per colour-clock cycle, which requester owns the shared chip-memory bus. It runs a horizontal position counter over each scanline. Fixed even positions on the line are reserved for memory refresh, disk, audio, sprite and bitplane transfers. Every other position, and every reserved position whose owner is idle, is offered to three shared requesters in fixed order: display coprocessor, then block-transfer engine, then CPU.

The line is 227.5 cycles long. To model this, the counter alternates between lines of 227 and 228 positions. Positions 226 and above never grant. When the wide-display mode is on, a pending bitplane fetch inside the fetch window takes over sprite slots. Requests are sampled at one position, and the grant for that position appears, registered, in the following cycle.

Top module: `dma_slot_arbiter`

## Requirements
- R1: While `rst` is high, `hpos` reads 0 and `grant` reads all zeros.
- R2: `hpos` steps by one each cycle. It wraps to 0 after position 226 on the first line after reset and after position 227 on the next line, and it keeps alternating between the two.
- R3: `grant` is registered. The value seen in the cycle after the counter shows position p is the decision for p, made from the requests sampled while `hpos` was p. At most one bit is set. Bit map: [0] refresh, [1] disk, [5:2] audio channels 0..3, [13:6] sprite channels 0..7, [14] bitplane, [15] coprocessor, [16] block-transfer engine, [17] CPU.
- R4: No grant is issued for positions 226 and 227.
- R5: Positions 2, 4, 6 and 8 always grant refresh, whatever the requests.
- R6: Positions 10, 12 and 14 grant disk when `req_disk` is high. Position 16+2k grants audio channel k when `req_aud[k]` is high.
- R7: Positions 24+4c and 26+4c grant sprite channel c when `req_spr[c]` is high, unless R9 applies.
- R8: The even positions 56 to 214 grant bitplane when `req_bpl` and `bpl_window` are both high.
- R9: When `wide_mode`, `bpl_window` and `req_bpl` are all high at a sprite position, bitplane wins that slot over the sprite.
- R10: Position 0, odd positions below 226, and reserved positions whose owner did not win go to the coprocessor, else the block-transfer engine, else the CPU. If none of them requests, no grant is issued.
- R11: The CPU and the block-transfer engine receive no grant while the coprocessor requests continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Colour-clock |
| rst | input | 1 | Synchronous reset, active high |
| req_disk | input | 1 | Disk transfer request |
| req_aud | input | 4 | Audio channel requests |
| req_spr | input | 8 | Sprite channel requests |
| req_bpl | input | 1 | Bitplane fetch request |
| req_cop | input | 1 | Display coprocessor request |
| req_blt | input | 1 | Block-transfer engine request |
| req_cpu | input | 1 | CPU request |
| wide_mode | input | 1 | Wide display: bitplane may take sprite slots |
| bpl_window | input | 1 | Current position lies in the bitplane fetch window |
| hpos | output | 8 | Current horizontal position |
| grant | output | 18 | One-hot grant for the previous position |

## Verification
The collisions of interest are a reserved owner and a shared requester asking at the same position, and bitplane and sprite asking together at a sprite slot in wide mode. The bench provokes these by holding every request high, by driving random request patterns with wide mode off and then on, and by a phase in which the three shared requesters ask continuously. A behavioural model built from a per-position owner table predicts every grant, and each cycle the model and the design are compared. The starvation phase must also end with no CPU and no block-transfer grant.

// File: rtl/dma_slot_arbiter.sv
module dma_slot_arbiter #(
  parameter int N_AUD = 4,
  parameter int N_SPR = 8,
  parameter int LINE_SHORT = 227,
  parameter int ALLOC = 226,
  parameter int N_REF = 4,
  parameter int N_DSK = 3,
  parameter int N_BPL = 80
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_disk,
  input  logic [N_AUD-1:0]         req_aud,
  input  logic [N_SPR-1:0]         req_spr,
  input  logic                     req_bpl,
  input  logic                     req_cop,
  input  logic                     req_blt,
  input  logic                     req_cpu,
  input  logic                     wide_mode,
  input  logic                     bpl_window,
  output logic [$clog2(LINE_SHORT+1)-1:0] hpos,
  output logic [N_AUD+N_SPR+5:0]   grant
);
  localparam int PW  = $clog2(LINE_SHORT+1);
  localparam int GW  = N_AUD + N_SPR + 6;
  localparam int AW  = (N_AUD > 1) ? $clog2(N_AUD) : 1;
  localparam int SW  = (N_SPR > 1) ? $clog2(N_SPR) : 1;
  localparam int G_DSK = 1;
  localparam int G_AUD = 2;
  localparam int G_SPR = G_AUD + N_AUD;
  localparam int G_BPL = G_SPR + N_SPR;
  localparam int G_COP = G_BPL + 1;
  localparam int G_BLT = G_BPL + 2;
  localparam int G_CPU = G_BPL + 3;
  localparam logic [PW-1:0] P_REF  = PW'(2);
  localparam logic [PW-1:0] P_DSK  = P_REF + PW'(2*N_REF);
  localparam logic [PW-1:0] P_AUD  = P_DSK + PW'(2*N_DSK);
  localparam logic [PW-1:0] P_SPR  = P_AUD + PW'(2*N_AUD);
  localparam logic [PW-1:0] P_BPL  = P_SPR + PW'(4*N_SPR);
  localparam logic [PW-1:0] P_END  = P_BPL + PW'(2*N_BPL);
  localparam logic [PW-1:0] P_ALLOC = PW'(ALLOC);
  localparam logic [PW-1:0] P_LAST_S = PW'(LINE_SHORT-1);
  localparam logic [PW-1:0] P_LAST_L = PW'(LINE_SHORT);

  logic          long_line;
  logic [GW-1:0] nxt;
  logic          even, at_ref, at_dsk, at_aud, at_spr, at_bpl;
  logic [PW-1:0] off_aud, off_spr;
  logic [PW-1:0] last;

  assign even    = ~hpos[0];
  assign at_ref  = even && hpos >= P_REF && hpos < P_DSK;
  assign at_dsk  = even && hpos >= P_DSK && hpos < P_AUD;
  assign at_aud  = even && hpos >= P_AUD && hpos < P_SPR;
  assign at_spr  = even && hpos >= P_SPR && hpos < P_BPL;
  assign at_bpl  = even && hpos >= P_BPL && hpos < P_END;
  assign off_aud = hpos - P_AUD;
  assign off_spr = hpos - P_SPR;
  assign last    = long_line ? P_LAST_L : P_LAST_S;

  always_comb begin
    nxt = '0;
    if (hpos >= P_ALLOC) begin
      nxt = '0;
    end else if (at_ref) begin
      nxt[0] = 1'b1;
    end else if (at_dsk && req_disk) begin
      nxt[G_DSK] = 1'b1;
    end else if (at_aud && req_aud[off_aud[1 +: AW]]) begin
      nxt[G_AUD + int'(off_aud[1 +: AW])] = 1'b1;
    end else if (at_spr && wide_mode && bpl_window && req_bpl) begin
      nxt[G_BPL] = 1'b1;
    end else if (at_spr && req_spr[off_spr[2 +: SW]]) begin
      nxt[G_SPR + int'(off_spr[2 +: SW])] = 1'b1;
    end else if (at_bpl && bpl_window && req_bpl) begin
      nxt[G_BPL] = 1'b1;
    end else if (req_cop) begin
      nxt[G_COP] = 1'b1;
    end else if (req_blt) begin
      nxt[G_BLT] = 1'b1;
    end else if (req_cpu) begin
      nxt[G_CPU] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hpos      <= '0;
      long_line <= 1'b0;
      grant     <= '0;
    end else begin
      grant <= nxt;
      if (hpos == last) begin
        hpos      <= '0;
        long_line <= ~long_line;
      end else begin
        hpos <= hpos + PW'(1);
      end
    end
  end

  p_single_grant_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  p_tail_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (hpos >= P_ALLOC) |=> (grant == '0));

  p_refresh_fixed_r5: assert property (@(posedge clk) disable iff (rst)
    (~hpos[0] && hpos >= P_REF && hpos < P_DSK) |=> grant[0]);

  p_cpu_lowest_r10: assert property (@(posedge clk) disable iff (rst)
    (req_cop || req_blt) |=> !grant[G_CPU]);

  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (hpos < P_LAST_S) |=> (hpos == $past(hpos) + PW'(1)));
endmodule

// File: tb/dma_slot_arbiter_test.sv
`timescale 1ns/1ps
module dma_slot_arbiter_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_disk = 0, req_bpl = 0, req_cop = 0, req_blt = 0, req_cpu = 0;
  logic [3:0] req_aud = '0;
  logic [7:0] req_spr = '0;
  logic wide_mode = 0, bpl_window = 0;
  logic [7:0] hpos;
  logic [17:0] grant;

  int checks = 0, failures = 0;
  int owner [0:227];
  int m_pos = 0, m_len = 227, phase = 0;
  logic [17:0] m_gnt = '0;
  string m_tag = "R3";
  int cpu_blt_starved = 0;

  dma_slot_arbiter uut (.clk(clk), .rst(rst), .req_disk(req_disk), .req_aud(req_aud),
    .req_spr(req_spr), .req_bpl(req_bpl), .req_cop(req_cop), .req_blt(req_blt),
    .req_cpu(req_cpu), .wide_mode(wide_mode), .bpl_window(bpl_window),
    .hpos(hpos), .grant(grant));

  always #2.5 clk = ~clk;

  // owner codes: -1 none, 0 shared only, 1 refresh, 2 disk, 10+k audio, 20+c sprite, 30 bitplane
  initial begin
    for (int p = 0; p < 228; p++) owner[p] = (p < 226) ? 0 : -1;
    for (int i = 0; i < 4; i++) owner[2 + 2*i] = 1;
    for (int i = 0; i < 3; i++) owner[10 + 2*i] = 2;
    for (int k = 0; k < 4; k++) owner[16 + 2*k] = 10 + k;
    for (int c = 0; c < 8; c++) begin owner[24 + 4*c] = 20 + c; owner[26 + 4*c] = 20 + c; end
    for (int i = 0; i < 80; i++) owner[56 + 2*i] = 30;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h (pos %0d)", tag, act, exp, m_pos);
    end
  endtask

  task automatic predict();
    int o;
    logic [17:0] g;
    o = owner[m_pos];
    g = '0;
    m_tag = "R10";
    if (o == -1) m_tag = "R4";
    else if (o == 1) begin g[0] = 1; m_tag = "R5"; end
    else if (o == 2 && req_disk) begin g[1] = 1; m_tag = "R6"; end
    else if (o >= 10 && o < 14 && req_aud[o-10]) begin g[2 + o - 10] = 1; m_tag = "R6"; end
    else if (o >= 20 && o < 28 && wide_mode && bpl_window && req_bpl) begin g[14] = 1; m_tag = "R9"; end
    else if (o >= 20 && o < 28 && req_spr[o-20]) begin g[6 + o - 20] = 1; m_tag = "R7"; end
    else if (o == 30 && bpl_window && req_bpl) begin g[14] = 1; m_tag = "R8"; end
    if (o != -1 && g == '0) begin
      if (req_cop) g[15] = 1;
      else if (req_blt) g[16] = 1;
      else if (req_cpu) g[17] = 1;
    end
    m_gnt = g;
    if (m_pos == m_len - 1) begin
      m_pos = 0;
      m_len = (m_len == 227) ? 228 : 227;
    end else m_pos++;
  endtask

  task automatic drive();
    logic r;
    r = 1'b1;
    case (phase)
      0: begin req_disk = 1; req_aud = '1; req_spr = '1; req_bpl = 1; req_cop = 1;
               req_blt = 1; req_cpu = 1; wide_mode = 0; bpl_window = 1; end
      1: begin req_disk = 0; req_aud = '0; req_spr = '0; req_bpl = 0; req_cop = 0;
               req_blt = 0; req_cpu = 0; wide_mode = 0; bpl_window = 0; end
      default: begin
        req_disk = 1'($urandom); req_aud = 4'($urandom); req_spr = 8'($urandom);
        req_bpl = 1'($urandom); req_cop = 1'($urandom); req_blt = 1'($urandom);
        req_cpu = 1'($urandom);
        wide_mode = (phase == 3) ? 1'b1 : (phase == 4 ? 1'($urandom) : 1'b0);
        bpl_window = (m_pos >= 30 && m_pos < 200) ? 1'b1 : 1'($urandom);
        if (phase == 4) begin req_cop = 1; req_blt = 1; req_cpu = 1; end
      end
    endcase
    r = r;
  endtask

  task automatic step();
    check("R2", 32'(hpos), 32'(m_pos));
    check(m_tag, 32'(grant), 32'(m_gnt));
    check("R3", 32'($countones(grant) <= 1), 32'd1);
    if (phase == 4 && (grant[16] || grant[17])) cpu_blt_starved++;
    drive();
    predict();
  endtask

  initial begin
    #(5.0 * 200000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    req_cop = 1; req_cpu = 1; req_bpl = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1", 32'(hpos), 32'd0);
    check("R1", 32'(grant), 32'd0);
    req_cop = 0; req_cpu = 0; req_bpl = 0;
    rst = 1'b0;
    drive();
    predict();
    for (int ph = 0; ph < 5; ph++) begin
      phase = ph;
      for (int n = 0; n < 3 * 228; n++) begin
        @(negedge clk);
        step();
      end
    end
    @(negedge clk);
    check("R11", 32'(cpu_blt_starved), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule